// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the execute stage of an in-order five-stage integer pipeline. It picks each of the two ALU operands from one of three places: the register-file read data captured for the instruction now in execute, the ALU result held one stage later, or the write-back value held two stages later. The choice is made by comparing the two source register numbers of the execute-stage instruction with the destination register numbers of the two older instructions, qualified by their register-write enables.

The unit is purely combinational. It puts out the two 2-bit operand selects, for observation by neighbouring logic, and the two chosen operand words. A result that is being written back in the same cycle as the dependent read needs no path here, because the register file writes early in the cycle and reads late. Stall detection for a load followed by its consumer and the register file itself belong to other blocks. There is no stream traffic at this edge: every input is a plain per-cycle value and every output follows it in the same cycle, so no valid/ready handshake applies.

Top module: `fwd_unit`

## Requirements
- R1: Select code 2'b00 routes the register-file value to the operand, 2'b10 routes the later-stage ALU result, and 2'b01 routes the write-back value; each operand output equals the source named by its select in the same cycle.
- R2: The first-operand select is 2'b10 whenever the ALU-result stage has its write enable high, a nonzero destination, and that destination equals the first source register number.
- R3: The second-operand select is 2'b10 under the same conditions, matched against the second source register number.
- R4: When no ALU-result-stage match exists for an operand, its select is 2'b01 whenever the write-back stage has its write enable high, a nonzero destination, and that destination equals that operand's source register number.
- R5: When both older stages match the same source register, the ALU-result stage (the younger producer) wins and the select is 2'b10.
- R6: A destination of register 0 never causes forwarding, even with its write enable high; the operand then takes the register-file value.
- R7: A stage whose write enable is low never causes forwarding, whatever its destination number.
- R8: The select code 2'b11 is never produced.
- R9: The two operands are decided independently; when both source numbers name the same producer register, both operands are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register number of the execute-stage instruction |
| id_rt | input | 5 | Second source register number of the execute-stage instruction |
| rf_rs_data | input | 32 | Register-file value read for the first source |
| rf_rt_data | input | 32 | Register-file value read for the second source |
| exm_rd | input | 5 | Destination number held in the ALU-result stage |
| exm_wr | input | 1 | Register-write enable of the ALU-result stage |
| exm_alu | input | 32 | ALU result held in the ALU-result stage |
| mwb_rd | input | 5 | Destination number held in the write-back stage |
| mwb_wr | input | 1 | Register-write enable of the write-back stage |
| mwb_data | input | 32 | Value about to be written back |
| fwd_a_sel | output | 2 | Select applied to the first operand |
| fwd_b_sel | output | 2 | Select applied to the second operand |
| op_a | output | 32 | Chosen first operand |
| op_b | output | 32 | Chosen second operand |

## Verification
The assertions evaluate whenever the combinational outputs settle and take for granted that every input carries a known 0/1 value; an unknown register number or enable would make the match terms meaningless. The stimulus therefore drives every input from defined values at all times, holding them at zero during the bench's reset phase. Register numbers are drawn from a narrow range that includes zero so that matches, double matches and the register-0 case occur often, while enables and data words vary freely.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W_DEF  = 5;
  localparam int DATA_W_DEF = 32;
  localparam int NUM_OPS    = 2;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_WB = 2'b01,
    SEL_EX = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_detect.sv
module fwd_detect
  import fwd_pkg::*;
#(
  parameter int REG_W = REG_W_DEF
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_wr,
  output logic [1:0]       sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_hit;
  logic wb_hit;

  always_comb begin
    ex_hit = exm_wr && (exm_rd != ZERO_REG) && (exm_rd == src);
    wb_hit = mwb_wr && (mwb_rd != ZERO_REG) && (mwb_rd == src);
    if (ex_hit)      sel = SEL_EX;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] out_val
);
  always_comb begin
    case (sel)
      SEL_EX:  out_val = ex_val;
      SEL_WB:  out_val = wb_val;
      default: out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = REG_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [DATA_W-1:0] rf_rs_data,
  input  logic [DATA_W-1:0] rf_rt_data,
  input  logic [REG_W-1:0]  exm_rd,
  input  logic              exm_wr,
  input  logic [DATA_W-1:0] exm_alu,
  input  logic [REG_W-1:0]  mwb_rd,
  input  logic              mwb_wr,
  input  logic [DATA_W-1:0] mwb_data,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  logic [NUM_OPS-1:0][REG_W-1:0]  src;
  logic [NUM_OPS-1:0][DATA_W-1:0] rf_val;
  logic [NUM_OPS-1:0][1:0]        sel;
  logic [NUM_OPS-1:0][DATA_W-1:0] opv;

  assign src[0]    = id_rs;
  assign src[1]    = id_rt;
  assign rf_val[0] = rf_rs_data;
  assign rf_val[1] = rf_rt_data;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_detect #(.REG_W(REG_W)) u_det (
      .src    (src[g]),
      .exm_rd (exm_rd),
      .exm_wr (exm_wr),
      .mwb_rd (mwb_rd),
      .mwb_wr (mwb_wr),
      .sel    (sel[g])
    );
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel[g]),
      .rf_val  (rf_val[g]),
      .ex_val  (exm_alu),
      .wb_val  (mwb_data),
      .out_val (opv[g])
    );
  end

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];
  assign op_a      = opv[0];
  assign op_b      = opv[1];

  // Checks across the detector and multiplexer instances.
  always_comb begin
    // R1: operand agrees with the code chosen by the detector
    assert_oper_a_route_R1: assert (fwd_a_sel != 2'b01 || op_a == mwb_data);
    assert_oper_b_route_R1: assert (fwd_b_sel != 2'b10 || op_b == exm_alu);
    // R2: younger-stage match on first source forces the EX code
    assert_a_ex_match_R2: assert (!(exm_wr && exm_rd != '0 && exm_rd == id_rs) || fwd_a_sel == 2'b10);
    // R3: same on second source
    assert_b_ex_match_R3: assert (!(exm_wr && exm_rd != '0 && exm_rd == id_rt) || fwd_b_sel == 2'b10);
    // R6: register 0 alone never forwards
    assert_zero_reg_R6: assert (!(exm_rd == '0 && mwb_rd == '0) || (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));
    // R7: with both enables low nothing forwards
    assert_no_wr_R7: assert (exm_wr || mwb_wr || (op_a == rf_rs_data && op_b == rf_rt_data));
    // R8: unused code never appears
    assert_no_code3_R8: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);
  end
endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_RAND     = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  id_rs, id_rt, exm_rd, mwb_rd;
  logic        exm_wr, mwb_wr;
  logic [31:0] rf_rs_data, rf_rt_data, exm_alu, mwb_data;
  logic [1:0]  fwd_a_sel, fwd_b_sel;
  logic [31:0] op_a, op_b;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  fwd_unit u0 (
    .id_rs(id_rs), .id_rt(id_rt), .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .exm_rd(exm_rd), .exm_wr(exm_wr), .exm_alu(exm_alu),
    .mwb_rd(mwb_rd), .mwb_wr(mwb_wr), .mwb_data(mwb_data),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .op_a(op_a), .op_b(op_b)
  );

  // Behavioural reference: code for one source number.
  function automatic int ref_code(int s);
    if (exm_wr && exm_rd != 0 && int'(exm_rd) == s) return 2;
    if (mwb_wr && mwb_rd != 0 && int'(mwb_rd) == s) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_val(int code, logic [31:0] rf);
    if (code == 2) return exm_alu;
    if (code == 1) return mwb_data;
    return rf;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      int ca, cb;
      ca = ref_code(int'(id_rs));
      cb = ref_code(int'(id_rt));
      chk("R2 sel_a", {30'd0, fwd_a_sel}, ca);
      chk("R3 sel_b", {30'd0, fwd_b_sel}, cb);
      chk("R1 op_a", op_a, ref_val(ca, rf_rs_data));
      chk("R1 op_b", op_b, ref_val(cb, rf_rt_data));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(int rs, int rt, int erd, bit ewr, int wrd, bit wwr);
    @(posedge clk);
    id_rs = rs[4:0]; id_rt = rt[4:0];
    exm_rd = erd[4:0]; exm_wr = ewr;
    mwb_rd = wrd[4:0]; mwb_wr = wwr;
    rf_rs_data = 32'hA0A0_0001; rf_rt_data = 32'hB0B0_0002;
    exm_alu = 32'hE0E0_0003;    mwb_data = 32'hD0D0_0004;
    @(negedge clk);
  endtask

  initial begin
    id_rs = '0; id_rt = '0; exm_rd = '0; mwb_rd = '0;
    exm_wr = 0; mwb_wr = 0;
    rf_rs_data = '0; rf_rt_data = '0; exm_alu = '0; mwb_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset sel_a", {30'd0, fwd_a_sel}, 0);
    chk("reset op_a", op_a, 0);
    rst = 0;

    drive(3, 4, 3, 1, 0, 0);   // R2
    chk("R2 directed sel_a", {30'd0, fwd_a_sel}, 2);
    chk("R2 directed op_a", op_a, 32'hE0E0_0003);
    chk("R2 directed sel_b", {30'd0, fwd_b_sel}, 0);

    drive(4, 7, 7, 1, 0, 0);   // R3
    chk("R3 directed sel_b", {30'd0, fwd_b_sel}, 2);
    chk("R3 directed op_b", op_b, 32'hE0E0_0003);

    drive(9, 9, 2, 1, 9, 1);   // R4, R9
    chk("R4 directed sel_a", {30'd0, fwd_a_sel}, 1);
    chk("R9 directed sel_b", {30'd0, fwd_b_sel}, 1);
    chk("R4 directed op_a", op_a, 32'hD0D0_0004);

    drive(6, 6, 6, 1, 6, 1);   // R5, R9
    chk("R5 precedence sel_a", {30'd0, fwd_a_sel}, 2);
    chk("R5 precedence op_b", op_b, 32'hE0E0_0003);

    drive(0, 0, 0, 1, 0, 1);   // R6
    chk("R6 zero sel_a", {30'd0, fwd_a_sel}, 0);
    chk("R6 zero op_b", op_b, 32'hB0B0_0002);

    drive(0, 5, 0, 1, 5, 1);   // R6 ex blocked, wb hits rt
    chk("R6 zero op_a", op_a, 32'hA0A0_0001);
    chk("R4 wb op_b", op_b, 32'hD0D0_0004);

    drive(8, 8, 8, 0, 8, 0);   // R7
    chk("R7 no write sel_a", {30'd0, fwd_a_sel}, 0);
    chk("R7 no write op_b", op_b, 32'hB0B0_0002);

    for (int i = 0; i < N_RAND; i++) begin
      @(posedge clk);
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      exm_rd = 5'($urandom_range(0, 3)); mwb_rd = 5'($urandom_range(0, 3));
      exm_wr = 1'($urandom); mwb_wr = 1'($urandom);
      rf_rs_data = $urandom; rf_rt_data = $urandom;
      exm_alu = $urandom;    mwb_data = $urandom;
      @(negedge clk);
      if (fwd_a_sel == 2'b11 || fwd_b_sel == 2'b11)
        chk("R8 code 3", {28'd0, fwd_a_sel, fwd_b_sel}, 0);
    end

    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule